// File: doc/BRIEF.md
# Data-Valid and Field Flag Generator

This block drives the two status lines of a broadcast data-line receiver: an active-low data-available flag and an active-high first-field indicator. The acquisition path sends a one-cycle commit strobe when a line has been stored. The strobe carries a two-bit code that says which kind of data the line held. The block pulls the data-available flag low only when that code matches the kind selected by the current operating-mode bits. It then releases the flag on the clearing event that belongs to that mode. For dedicated-line mode this is the start of line 16. For the packet and header modes it is the start of the next data-entry window.

A not-acknowledge from the host interface, given before the host ends a read, also releases the flag in every mode. The field indicator loads the field identity on each field-start strobe. When the test input is high, both outputs follow the chip-select input, while the internal flag state keeps tracking events. All status outputs come from flip-flops and change on the clock edge that samples the causing strobe.

Top module: `dvf_flags`

## Requirements
- R1: While reset is asserted and on leaving it, `dav_n` is 1 and `first_field` is 0.
- R2: The selected data kind comes from `mode_bits`: bit 1 = 0 selects kind 0 (dedicated line). Otherwise bit 0 = 0 selects kind 1 (format-2 packet). Otherwise bit 2 = 0 selects kind 2 (format-1 packet), and bit 2 = 1 selects kind 3 (header row).
- R3: A `commit_stb` whose `commit_kind` equals the selected kind drives `dav_n` to 0 on the next clock edge.
- R4: A `commit_stb` whose `commit_kind` differs from the selected kind leaves `dav_n` unchanged.
- R5: With `mode_bits[1]` = 0, `line16_stb` sets `dav_n` to 1 on the next edge, and `window_stb` has no effect on it.
- R6: With `mode_bits[1]` = 1, `window_stb` sets `dav_n` to 1 on the next edge, and `line16_stb` has no effect on it.
- R7: `host_nack_stb` sets `dav_n` to 1 on the next edge in every mode.
- R8: A matching commit in the same cycle as any clearing event leaves `dav_n` at 0.
- R9: On `field_stb`, `first_field` takes the value of `field_is_first` at the next edge. Without `field_stb` it holds.
- R10: While `test_mode` is 1, both outputs equal `chip_sel` one edge later. The flag and field state keep updating, and the outputs show that state again one edge after `test_mode` returns to 0.
- R11: With no strobe and with test mode off in the current and the previous cycle, neither output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_bits | input | 3 | Operating-mode bits (see R2) |
| line16_stb | input | 1 | One-cycle strobe at the start of line 16 |
| window_stb | input | 1 | One-cycle strobe at the start of the data-entry window |
| field_stb | input | 1 | One-cycle strobe at the start of each field |
| field_is_first | input | 1 | Field identity, 1 for the first field, sampled on `field_stb` |
| commit_stb | input | 1 | One-cycle strobe: acquisition stored a valid line |
| commit_kind | input | 2 | Kind of the committed line (0..3, see R2) |
| host_nack_stb | input | 1 | One-cycle strobe: host did not acknowledge before ending a read |
| test_mode | input | 1 | Test input; when high the outputs mirror `chip_sel` |
| chip_sel | input | 1 | Chip-select level mirrored in test mode |
| dav_n | output | 1 | Data-available flag, active low |
| first_field | output | 1 | First-field indicator, active high |

## Verification
The assertions assume that every strobe is high for one clock only. They also assume that `commit_kind` is stable while `commit_stb` is high, and that `test_mode`, `chip_sel` and `field_is_first` are levels that change at most once per cycle. The stimulus drives every input on the falling edge and holds it for exactly one period per step, so each strobe is a single-cycle pulse. The hold property needs two quiet cycles of test mode, and the test-mode sequence in the bench leaves at least one idle step after test mode is switched off.

// File: rtl/dvf_pkg.sv
package dvf_pkg;
   localparam int KIND_BITS = 2;
   typedef enum logic [KIND_BITS-1:0] {
      KIND_LINE16 = 2'd0,
      KIND_FMT2   = 2'd1,
      KIND_FMT1   = 2'd2,
      KIND_HDR    = 2'd3
   } kind_e;
   localparam int MB_FMT1 = 0;
   localparam int MB_PDC  = 1;
   localparam int MB_HDR  = 2;
endpackage

// File: rtl/dvf_kind_sel.sv
module dvf_kind_sel #(
   parameter int MODE_W = 3,
   parameter int KIND_W = 2
) (
   input  logic [MODE_W-1:0] mode_bits,
   output logic [KIND_W-1:0] sel_kind,
   output logic              pkt_mode
);
   import dvf_pkg::*;
   always_comb begin
      pkt_mode = mode_bits[MB_PDC];
      if (!mode_bits[MB_PDC])       sel_kind = KIND_W'(KIND_LINE16);
      else if (!mode_bits[MB_FMT1]) sel_kind = KIND_W'(KIND_FMT2);
      else if (!mode_bits[MB_HDR])  sel_kind = KIND_W'(KIND_FMT1);
      else                          sel_kind = KIND_W'(KIND_HDR);
   end
endmodule

// File: rtl/dvf_dav_ctl.sv
module dvf_dav_ctl #(
   parameter int KIND_W      = 2,
   parameter bit NACK_CLEARS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_stb,
   input  logic [KIND_W-1:0] commit_kind,
   input  logic [KIND_W-1:0] sel_kind,
   input  logic              pkt_mode,
   input  logic              line16_stb,
   input  logic              window_stb,
   input  logic              host_nack_stb,
   output logic              avail_nxt,
   output logic              avail_q
);
   logic hit;
   logic mode_clr;
   logic nack_clr;

   generate
      if (NACK_CLEARS) begin : g_nack
         assign nack_clr = host_nack_stb;
      end else begin : g_no_nack
         assign nack_clr = 1'b0;
      end
   endgenerate

   assign hit      = commit_stb && (commit_kind == sel_kind);
   assign mode_clr = pkt_mode ? window_stb : line16_stb;

   always_comb begin
      if (hit)                      avail_nxt = 1'b1;
      else if (mode_clr || nack_clr) avail_nxt = 1'b0;
      else                          avail_nxt = avail_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) avail_q <= 1'b0;
      else        avail_q <= avail_nxt;
   end

   // R8: a matching commit is never lost to a same-cycle clear
   p_commit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (mode_clr || host_nack_stb)) |=> avail_q);
endmodule

// File: rtl/dvf_field_trk.sv
module dvf_field_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic field_stb,
   input  logic field_is_first,
   output logic fld_nxt,
   output logic fld_q
);
   assign fld_nxt = field_stb ? field_is_first : fld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= 1'b0;
      else        fld_q <= fld_nxt;
   end

   p_field_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !field_stb |=> $stable(fld_q));
endmodule

// File: rtl/dvf_out_stage.sv
module dvf_out_stage #(
   parameter bit TEST_MIRROR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic test_mode,
   input  logic chip_sel,
   input  logic avail_nxt,
   input  logic fld_nxt,
   output logic dav_n,
   output logic first_field
);
   logic dav_d;
   logic fld_d;

   generate
      if (TEST_MIRROR) begin : g_mirror
         assign dav_d = test_mode ? chip_sel : !avail_nxt;
         assign fld_d = test_mode ? chip_sel : fld_nxt;
      end else begin : g_plain
         logic unused_in;
         assign unused_in = test_mode ^ chip_sel;
         assign dav_d = !avail_nxt;
         assign fld_d = fld_nxt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dav_n       <= 1'b1;
         first_field <= 1'b0;
      end else begin
         dav_n       <= dav_d;
         first_field <= fld_d;
      end
   end
endmodule

// File: rtl/dvf_flags.sv
module dvf_flags #(
   parameter int MODE_W      = 3,
   parameter int KIND_W      = 2,
   parameter bit TEST_MIRROR = 1'b1,
   parameter bit NACK_CLEARS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_bits,
   input  logic              line16_stb,
   input  logic              window_stb,
   input  logic              field_stb,
   input  logic              field_is_first,
   input  logic              commit_stb,
   input  logic [KIND_W-1:0] commit_kind,
   input  logic              host_nack_stb,
   input  logic              test_mode,
   input  logic              chip_sel,
   output logic              dav_n,
   output logic              first_field
);
   localparam int MIN_MODE_W = dvf_pkg::MB_HDR + 1;

   generate
      if (MODE_W < MIN_MODE_W) begin : g_bad_mode
         $error("dvf_flags: MODE_W too small for the mode bits");
      end
      if (KIND_W < dvf_pkg::KIND_BITS) begin : g_bad_kind
         $error("dvf_flags: KIND_W cannot hold four kinds");
      end
   endgenerate

   logic [KIND_W-1:0] sel_kind;
   logic              pkt_mode;
   logic              avail_nxt;
   logic              avail_q;
   logic              fld_nxt;
   logic              fld_q;

   dvf_kind_sel #(.MODE_W(MODE_W), .KIND_W(KIND_W)) u_sel (
      .mode_bits (mode_bits),
      .sel_kind  (sel_kind),
      .pkt_mode  (pkt_mode)
   );

   dvf_dav_ctl #(.KIND_W(KIND_W), .NACK_CLEARS(NACK_CLEARS)) u_dav (
      .clk           (clk),
      .rst_n         (rst_n),
      .commit_stb    (commit_stb),
      .commit_kind   (commit_kind),
      .sel_kind      (sel_kind),
      .pkt_mode      (pkt_mode),
      .line16_stb    (line16_stb),
      .window_stb    (window_stb),
      .host_nack_stb (host_nack_stb),
      .avail_nxt     (avail_nxt),
      .avail_q       (avail_q)
   );

   dvf_field_trk u_fld (
      .clk            (clk),
      .rst_n          (rst_n),
      .field_stb      (field_stb),
      .field_is_first (field_is_first),
      .fld_nxt        (fld_nxt),
      .fld_q          (fld_q)
   );

   dvf_out_stage #(.TEST_MIRROR(TEST_MIRROR)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_mode   (test_mode),
      .chip_sel    (chip_sel),
      .avail_nxt   (avail_nxt),
      .fld_nxt     (fld_nxt),
      .dav_n       (dav_n),
      .first_field (first_field)
   );

   p_vps_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_stb && !mode_bits[1] && commit_kind == KIND_W'(0) && !test_mode) |=> !dav_n);

   p_mismatch_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_stb && !mode_bits[1] && commit_kind != KIND_W'(0) && !line16_stb
       && !host_nack_stb && !test_mode && !$past(test_mode)) |=> $stable(dav_n));

   p_line16_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line16_stb && !mode_bits[1] && !commit_stb && !test_mode) |=> dav_n);

   p_window_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (window_stb && mode_bits[1] && !commit_stb && !test_mode) |=> dav_n);

   p_nack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_nack_stb && !commit_stb && !test_mode) |=> dav_n);

   p_field_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (field_stb && !test_mode) |=> first_field == $past(field_is_first));

   p_test_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |=> (dav_n == $past(chip_sel)) && (first_field == $past(chip_sel)));

   p_quiet_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_stb && !line16_stb && !window_stb && !host_nack_stb && !field_stb
       && !test_mode && !$past(test_mode)) |=> ($stable(dav_n) && $stable(first_field)));
endmodule

// File: tb/tb_dvf_flags.sv
module tb_dvf_flags;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_bits = '0;
   logic       line16_stb = 1'b0, window_stb = 1'b0, field_stb = 1'b0;
   logic       field_is_first = 1'b0, commit_stb = 1'b0, host_nack_stb = 1'b0;
   logic [1:0] commit_kind = '0;
   logic       test_mode = 1'b0, chip_sel = 1'b0;
   logic       dav_n, first_field;

   always #10 clk = ~clk;

   dvf_flags dut (
      .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .line16_stb(line16_stb),
      .window_stb(window_stb), .field_stb(field_stb), .field_is_first(field_is_first),
      .commit_stb(commit_stb), .commit_kind(commit_kind), .host_nack_stb(host_nack_stb),
      .test_mode(test_mode), .chip_sel(chip_sel), .dav_n(dav_n), .first_field(first_field)
   );

   typedef struct { string req; logic dav_n; logic ff; } item_t;
   item_t sb[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // level inputs, changed before a step
   logic [2:0] g_mode = '0;
   logic       g_tst = 1'b0, g_cs = 1'b0, g_fid = 1'b0;
   // reference state
   bit m_avail = 1'b0;
   bit m_ff    = 1'b0;

   task automatic step(input string req, input bit cmt, input logic [1:0] kind,
                       input bit l16, input bit win, input bit nack, input bit fstr);
      logic [1:0] sel;
      bit hit, clr;
      item_t it;
      @(negedge clk);
      mode_bits = g_mode; test_mode = g_tst; chip_sel = g_cs; field_is_first = g_fid;
      commit_stb = cmt; commit_kind = kind; line16_stb = l16; window_stb = win;
      host_nack_stb = nack; field_stb = fstr;
      if (!g_mode[1])      sel = 2'd0;
      else if (!g_mode[0]) sel = 2'd1;
      else if (!g_mode[2]) sel = 2'd2;
      else                 sel = 2'd3;
      hit = cmt && (kind == sel);
      clr = nack || (g_mode[1] ? win : l16);
      if (hit)      m_avail = 1'b1;
      else if (clr) m_avail = 1'b0;
      if (fstr) m_ff = g_fid;
      it.req   = req;
      it.dav_n = g_tst ? g_cs : !m_avail;
      it.ff    = g_tst ? g_cs : m_ff;
      sb.push_back(it);
   endtask

   task automatic idle(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 0, 2'd0, 0, 0, 0, 0);
   endtask

   // monitor: pops one expected item per edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() != 0) begin
            item_t e;
            e = sb.pop_front();
            checks++;
            if (dav_n !== e.dav_n || first_field !== e.ff) begin
               fails++;
               $display("FAIL %s: dav_n=%b first_field=%b expected dav_n=%b first_field=%b",
                        e.req, dav_n, first_field, e.dav_n, e.ff);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (dav_n !== 1'b1 || first_field !== 1'b0) begin
         fails++;
         $display("FAIL R1: dav_n=%b first_field=%b expected 1 0", dav_n, first_field);
      end
      rst_n = 1'b1;
      idle("R1", 2);

      // dedicated-line mode
      g_mode = 3'b000;
      step("R3", 1, 2'd0, 0, 0, 0, 0);
      idle("R11", 2);
      step("R5", 0, 2'd0, 1, 0, 0, 0);
      step("R4", 1, 2'd1, 0, 0, 0, 0);
      step("R4", 1, 2'd3, 0, 0, 0, 0);
      step("R3", 1, 2'd0, 0, 0, 0, 0);
      step("R5", 0, 2'd0, 0, 1, 0, 0);
      step("R5", 0, 2'd0, 1, 0, 0, 0);
      // format-2 packet mode
      g_mode = 3'b010;
      step("R2", 1, 2'd0, 0, 0, 0, 0);
      step("R3", 1, 2'd1, 0, 0, 0, 0);
      step("R6", 0, 2'd0, 1, 0, 0, 0);
      step("R6", 0, 2'd0, 0, 1, 0, 0);
      // format-1 packet mode
      g_mode = 3'b011;
      step("R4", 1, 2'd1, 0, 0, 0, 0);
      step("R2", 1, 2'd2, 0, 0, 0, 0);
      step("R4", 1, 2'd3, 0, 0, 0, 0);
      step("R7", 0, 2'd0, 0, 0, 1, 0);
      // header mode
      g_mode = 3'b111;
      step("R2", 1, 2'd2, 0, 0, 0, 0);
      step("R2", 1, 2'd3, 0, 0, 0, 0);
      step("R8", 1, 2'd3, 0, 1, 0, 0);
      step("R8", 1, 2'd3, 0, 0, 1, 0);
      step("R7", 0, 2'd0, 0, 0, 1, 0);
      g_mode = 3'b000;
      step("R8", 1, 2'd0, 1, 0, 1, 0);
      step("R7", 0, 2'd0, 0, 0, 1, 0);
      // field indicator
      g_fid = 1'b1;
      step("R9", 0, 2'd0, 0, 0, 0, 1);
      g_fid = 1'b0;
      idle("R9", 2);
      step("R9", 0, 2'd0, 0, 0, 0, 1);
      g_fid = 1'b1;
      step("R9", 0, 2'd0, 0, 0, 0, 1);
      // test mirror
      step("R3", 1, 2'd0, 0, 0, 0, 0);
      g_tst = 1'b1; g_cs = 1'b1;
      step("R10", 0, 2'd0, 0, 0, 0, 0);
      g_cs = 1'b0;
      step("R10", 0, 2'd0, 0, 0, 0, 0);
      g_fid = 1'b0;
      step("R10", 0, 2'd0, 0, 0, 0, 1);
      g_tst = 1'b0;
      idle("R10", 3);

      while (sb.size() != 0) @(posedge clk);
      #5;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule